// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block is a read-only instruction cache placed between a fetch unit and a slower backing memory. It stores 1 KB of code as two ways of 32 sets. Each line holds four 32-bit words. The fetch side presents a word address and holds it until the block answers. A hit is answered in the same cycle. On a miss the fetch side is stalled while the block reads the whole line, lowest word first, from the memory port. It then returns the requested word one cycle after the last beat.

Each line carries a lock bit, and replacement never picks a locked line. While `lockFill` is high, every line filled by a miss is locked, so a region of code can be preloaded and kept resident. If both ways of a set are locked, a miss reads only the requested word from memory and allocates nothing. A one-cycle `invAll` pulse drops every unlocked line and leaves locked lines valid. A one-cycle `unlockAll` pulse releases every lock.

Top module: `lockable_icache`

## Requirements
- R1: After reset, with no fetch request, `fetchValid`, `fetchStall` and `memReq` are low and every line is invalid, so the first fetch to any address misses.
- R2: A fetch that hits raises `fetchValid` in the same cycle with the stored word, keeps `fetchStall` low and makes no memory request.
- R3: A refilling miss makes exactly four memory beats at ascending addresses starting at the line base (word offset 0). `fetchValid` rises in the sixth cycle of the request, counting the miss cycle as the first, and returns the word the memory gave for the requested address.
- R4: On an allocating miss the victim is an invalid way if there is one, way 0 first. Otherwise the victim is the way the set used least recently, where both hits and fills count as use.
- R5: A line that is valid and locked is never chosen as a victim. If one way of a set is locked, the other way is replaced regardless of recency.
- R6: When both ways of the set are valid and locked, a miss makes a single memory beat at the requested address. It returns that word in the third cycle of the request and allocates nothing, so a repeated fetch misses again.
- R7: A line filled while `lockFill` is high becomes locked.
- R8: The cycle after `invAll` is high, every line that is not locked is invalid, and locked lines stay valid.
- R9: The cycle after `unlockAll` is high, no line is locked, so a later `invAll` removes those lines.
- R10: If `invAll` is high in the cycle of the final refill beat, the fetch still returns the correct word. The freshly filled line stays valid only if it was filled with `lockFill` high.
- R11: `fetchStall` is high exactly when `fetchReq` is high and `fetchValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request, held until `fetchValid` |
| fetchAddr | input | ADDR_W (20) | Word address of the fetch, held with the request |
| fetchValid | output | 1 | Fetched word is on `fetchData` this cycle |
| fetchStall | output | 1 | Request pending and not yet answered |
| fetchData | output | DATA_W (32) | Returned instruction word |
| memReq | output | 1 | Memory read beat requested |
| memAddr | output | ADDR_W (20) | Word address of the memory beat |
| memAck | input | 1 | Memory supplies `memData` for `memAddr` this cycle |
| memData | input | DATA_W (32) | Memory read data |
| invAll | input | 1 | Pulse: invalidate every unlocked line |
| unlockAll | input | 1 | Pulse: clear every lock bit |
| lockFill | input | 1 | Level: lock lines filled while high |

## Verification
Global invalidation and the commit of a refilled line can fall in the same cycle. The bench provokes this by raising `invAll` exactly in the cycle of the fourth memory beat of a miss. It does this once with `lockFill` low and once with it high. Each case is judged at the ports: the word returned must be correct, and the following fetch of the same address must miss with four beats when the line was unlocked, and hit with no beats when it was locked.

// File: rtl/icachePkg.sv
package icachePkg;
  localparam int LINE_WORDS = 4;
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BYPASS,
    ST_RESP
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             startMiss;
    logic             wordWr;
    logic             lineCommit;
    logic             bypassBeat;
    logic             lruTouch;
    logic             useHeld;
    logic [OFF_W-1:0] wordIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/icacheCtrl.sv
module icacheCtrl
  import icachePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic             hit,
  input  logic             bothLocked,
  input  logic             memAck,
  input  logic [OFF_W-1:0] reqOff,
  output ctlStrobe_t       ctl,
  output logic             memReq,
  output logic             fetchValid
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  ctlState_e        stQ, stD;
  logic [OFF_W-1:0] beatQ, beatD;

  always_comb begin
    ctl        = '0;
    stD        = stQ;
    beatD      = beatQ;
    memReq     = 1'b0;
    fetchValid = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        if (fetchReq && hit) begin
          fetchValid   = 1'b1;
          ctl.lruTouch = 1'b1;
        end else if (fetchReq) begin
          ctl.startMiss = 1'b1;
          beatD         = '0;
          stD           = bothLocked ? ST_BYPASS : ST_FILL;
        end
      end
      ST_FILL: begin
        memReq      = 1'b1;
        ctl.wordIdx = beatQ;
        if (memAck) begin
          ctl.wordWr = 1'b1;
          beatD      = beatQ + 1'b1;
          if (beatQ == LAST_BEAT) begin
            ctl.lineCommit = 1'b1;
            stD            = ST_RESP;
          end
        end
      end
      ST_BYPASS: begin
        memReq      = 1'b1;
        ctl.wordIdx = reqOff;
        if (memAck) begin
          ctl.bypassBeat = 1'b1;
          stD            = ST_RESP;
        end
      end
      ST_RESP: begin
        fetchValid  = 1'b1;
        ctl.useHeld = 1'b1;
        stD         = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      beatQ <= '0;
    end else begin
      stQ   <= stD;
      beatQ <= beatD;
    end
  end
endmodule

// File: rtl/icacheDatapath.sv
module icacheDatapath
  import icachePkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int SETS   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  ctlStrobe_t        ctl,
  input  logic              invAll,
  input  logic              unlockAll,
  input  logic              lockFill,
  input  logic [DATA_W-1:0] memData,
  output logic              hit,
  output logic              bothLocked,
  output logic [DATA_W-1:0] hitData,
  output logic [DATA_W-1:0] heldData
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0] tagIn;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  assign tagIn = fetchAddr[ADDR_W-1 -: TAG_W];
  assign idx   = fetchAddr[OFF_W +: IDX_W];
  assign off   = fetchAddr[OFF_W-1:0];

  logic [TAG_W-1:0]  tagMem  [WAYS][SETS];
  logic [DATA_W-1:0] dataMem [WAYS][SETS][LINE_WORDS];
  logic [WAYS-1:0][SETS-1:0] validQ, lockQ, validD, lockD;
  logic [SETS-1:0] lruQ;  // way to evict next
  logic [WAYS-1:0] wayHit, wayPinned;
  logic victimD, victimQ;
  logic [DATA_W-1:0] heldQ;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayHit[w]    = validQ[w][idx] && (tagMem[w][idx] == tagIn);
    assign wayPinned[w] = validQ[w][idx] && lockQ[w][idx];

    always_comb begin
      validD[w] = validQ[w];
      lockD[w]  = lockQ[w];
      if (ctl.lineCommit && (victimQ == 1'(w))) begin
        validD[w][idx] = 1'b1;
        lockD[w][idx]  = lockFill;
      end
      if (unlockAll) lockD[w] = '0;
      if (invAll)    validD[w] = validD[w] & lockD[w];
    end
  end

  assign hit        = |wayHit;
  assign bothLocked = &wayPinned;
  assign hitData    = wayHit[1] ? dataMem[1][idx][off] : dataMem[0][idx][off];
  assign heldData   = heldQ;

  always_comb begin
    if (wayPinned[0])        victimD = 1'b1;
    else if (wayPinned[1])   victimD = 1'b0;
    else if (!validQ[0][idx]) victimD = 1'b0;
    else if (!validQ[1][idx]) victimD = 1'b1;
    else                     victimD = lruQ[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      lockQ   <= '0;
      lruQ    <= '0;
      victimQ <= 1'b0;
    end else begin
      validQ <= validD;
      lockQ  <= lockD;
      if (ctl.startMiss)       victimQ   <= victimD;
      if (ctl.lruTouch)        lruQ[idx] <= !wayHit[1];
      else if (ctl.lineCommit) lruQ[idx] <= !victimQ;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wordWr) dataMem[victimQ][idx][ctl.wordIdx] <= memData;
    if (ctl.lineCommit) tagMem[victimQ][idx] <= tagIn;
    if ((ctl.wordWr && (ctl.wordIdx == off)) || ctl.bypassBeat) heldQ <= memData;
  end
endmodule

// File: rtl/lockable_icache.sv
module lockable_icache
  import icachePkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int SETS   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic              fetchStall,
  output logic [DATA_W-1:0] fetchData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  input  logic              invAll,
  input  logic              unlockAll,
  input  logic              lockFill
);
  ctlStrobe_t        ctl;
  logic              hit, bothLocked;
  logic [DATA_W-1:0] hitData, heldData;

  icacheCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchReq  (fetchReq),
    .hit       (hit),
    .bothLocked(bothLocked),
    .memAck    (memAck),
    .reqOff    (fetchAddr[OFF_W-1:0]),
    .ctl       (ctl),
    .memReq    (memReq),
    .fetchValid(fetchValid)
  );

  icacheDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fetchAddr (fetchAddr),
    .ctl       (ctl),
    .invAll    (invAll),
    .unlockAll (unlockAll),
    .lockFill  (lockFill),
    .memData   (memData),
    .hit       (hit),
    .bothLocked(bothLocked),
    .hitData   (hitData),
    .heldData  (heldData)
  );

  assign memAddr    = {fetchAddr[ADDR_W-1:OFF_W], ctl.wordIdx};
  assign fetchData  = ctl.useHeld ? heldData : hitData;
  assign fetchStall = fetchReq && !fetchValid;
endmodule

// File: rtl/icacheChecker.sv
module icacheChecker #(
  parameter int ADDR_W = 20,
  parameter int SETS   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                fetchReq,
  input logic                fetchValid,
  input logic                fetchStall,
  input logic                memReq,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                invAll,
  input logic                unlockAll,
  input logic [2*SETS-1:0]   validVec,
  input logic [2*SETS-1:0]   lockVec
);
  logic [2:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)       runLen <= '0;
    else if (memReq) runLen <= (runLen == 3'd7) ? runLen : runLen + 3'd1;
    else             runLen <= '0;
  end

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !memReq);
  p_valid_no_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !fetchStall);
  p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |-> !fetchStall);
  p_beats_ascend_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> (memAddr == $past(memAddr) + 1'b1));
  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= 3'd4);
  p_resident_r5: assert property (@(posedge clk) disable iff (!rstN)
    !unlockAll |=> ($countones(validVec & lockVec) >= $past($countones(validVec & lockVec))));
  p_inv_unlocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> ((validVec & ~lockVec) == '0));
  p_unlock_r9: assert property (@(posedge clk) disable iff (!rstN)
    unlockAll |=> (lockVec == '0));
endmodule

bind lockable_icache icacheChecker #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchReq  (fetchReq),
  .fetchValid(fetchValid),
  .fetchStall(fetchStall),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .invAll    (invAll),
  .unlockAll (unlockAll),
  .validVec  (u_dp.validQ),
  .lockVec   (u_dp.lockQ)
);

// File: tb/lockable_icache_tb.sv
module lockable_icache_tb;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchReq = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic fetchValid, fetchStall, memReq, memAck;
  logic [DATA_W-1:0] fetchData, memData;
  logic [ADDR_W-1:0] memAddr;
  logic invAll = 1'b0, unlockAll = 1'b0, lockFill = 1'b0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  // backing memory: always ready, word = marker plus address
  assign memAck  = memReq;
  assign memData = {12'hA5C, memAddr};

  lockable_icache u_dut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchStall(fetchStall), .fetchData(fetchData),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .invAll(invAll), .unlockAll(unlockAll), .lockFill(lockFill)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              lf;
    logic [2:0]        beats;
    logic [2:0]        cyc;
  } vec_t;

  // set 3 LRU walk, then set 7; address = tag<<7 | set<<2 | word
  localparam vec_t VEC [10] = '{
    '{20'h0008C, 1'b0, 3'd4, 3'd6},  // A miss -> way0
    '{20'h0008E, 1'b0, 3'd0, 3'd1},  // A hit
    '{20'h0010D, 1'b0, 3'd4, 3'd6},  // B miss -> way1
    '{20'h0008F, 1'b0, 3'd0, 3'd1},  // A hit, B least recent
    '{20'h0018C, 1'b0, 3'd4, 3'd6},  // C evicts B
    '{20'h0008D, 1'b0, 3'd0, 3'd1},  // A hit
    '{20'h0010C, 1'b0, 3'd4, 3'd6},  // B evicts C
    '{20'h0008C, 1'b0, 3'd0, 3'd1},  // A still resident
    '{20'h0021C, 1'b0, 3'd4, 3'd6},  // D miss set 7
    '{20'h0021F, 1'b0, 3'd0, 3'd1}   // D hit
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic doFetch(input logic [ADDR_W-1:0] a, input logic lf,
                         input int expBeats, input int expCyc,
                         input int invAt, input string rq);
    int beats = 0;
    int cyc = 0;
    int ascErr = 0;
    int stallErr = 0;
    logic [ADDR_W-1:0] expA;
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = a; lockFill = lf;
    forever begin
      invAll = (cyc + 1 == invAt);
      #1;
      cyc++;
      if (fetchStall != !fetchValid) stallErr++;
      if (memReq) begin
        expA = (expBeats == 4) ? {a[ADDR_W-1:2], 2'(beats)} : a;
        if (memAddr != expA) ascErr++;
        beats++;
      end
      if (fetchValid || cyc > 40) break;
      @(negedge clk);
    end
    chk(fetchData == {12'hA5C, a}, rq, "data", fetchData, {12'hA5C, a});
    chk(beats == expBeats, rq, "memory beats", beats, expBeats);
    chk(cyc == expCyc, rq, "cycles to valid", cyc, expCyc);
    chk(ascErr == 0, "R3", "beat address order errors", ascErr, 0);
    chk(stallErr == 0, "R11", "stall mismatches", stallErr, 0);
    @(negedge clk);
    fetchReq = 1'b0; lockFill = 1'b0; invAll = 1'b0;
  endtask

  task automatic pulseInv();
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;
  endtask

  task automatic pulseUnlock();
    @(negedge clk); unlockAll = 1'b1;
    @(negedge clk); unlockAll = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: quiet outputs after reset
    chk(!fetchValid && !fetchStall && !memReq, "R1", "outputs after reset",
        {fetchValid, fetchStall, memReq}, 0);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 10; i++)
      doFetch(VEC[i].addr, VEC[i].lf, int'(VEC[i].beats), int'(VEC[i].cyc), -1, "R2 R3 R4");

    // R5 R7: set 9, way0 locked by E
    doFetch(20'h002A4, 1'b1, 4, 6, -1, "R7");   // E locked into way0
    doFetch(20'h00324, 1'b0, 4, 6, -1, "R5");   // F -> way1
    doFetch(20'h003A4, 1'b0, 4, 6, -1, "R5");   // G must evict F, not E
    doFetch(20'h002A4, 1'b0, 0, 1, -1, "R5");   // E resident
    doFetch(20'h00324, 1'b0, 4, 6, -1, "R5");   // F was evicted

    // R6: set 11 both locked
    doFetch(20'h0042C, 1'b1, 4, 6, -1, "R7");   // H
    doFetch(20'h004AC, 1'b1, 4, 6, -1, "R7");   // I
    doFetch(20'h0052D, 1'b0, 1, 3, -1, "R6");   // J bypass
    doFetch(20'h0052D, 1'b0, 1, 3, -1, "R6");   // J not allocated
    doFetch(20'h0042C, 1'b0, 0, 1, -1, "R6");   // H still resident
    doFetch(20'h004AC, 1'b0, 0, 1, -1, "R6");   // I still resident

    // R8: invalidate keeps locked lines
    pulseInv();
    doFetch(20'h0042C, 1'b0, 0, 1, -1, "R8");
    doFetch(20'h002A4, 1'b0, 0, 1, -1, "R8");
    doFetch(20'h00324, 1'b0, 4, 6, -1, "R8");   // unlocked F dropped
    doFetch(20'h0008C, 1'b0, 4, 6, -1, "R8");   // unlocked A dropped

    // R9: unlock then invalidate drops former locked lines
    pulseUnlock();
    doFetch(20'h0052D, 1'b0, 4, 6, -1, "R9");   // J now allocates
    pulseInv();
    doFetch(20'h004AC, 1'b0, 4, 6, -1, "R9");   // I gone
    doFetch(20'h002A4, 1'b0, 4, 6, -1, "R9");   // E gone

    // R10: invalidate in the final beat cycle
    doFetch(20'h005B4, 1'b0, 4, 6, 5, "R10");   // K unlocked
    doFetch(20'h005B4, 1'b0, 4, 6, -1, "R10");  // K was dropped
    doFetch(20'h00638, 1'b1, 4, 6, 5, "R10");   // L locked
    doFetch(20'h00638, 1'b0, 0, 1, -1, "R10");  // L kept

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule